// File: doc/BRIEF.md
# Serial-configured ten-output clock gate

This block is the control side of a ten-output clock fanout. A two-wire serial host configures it through a fixed block-transfer protocol, and its register bits decide, one output at a time, whether the buffered input clock is passed through or parked low. The serial lines are sampled in the system clock domain. The block pulls the data line low through an open-drain enable and never drives it high.

A write begins with the write address. Two filler bytes follow: a command code and a count. Both are acknowledged and then thrown away. The data bytes after them fill the registers strictly upward from register 0. A read has no index: the block sends a length byte and then every register in order. A global enable pin decides whether the output pads drive at all. The enable bit that changes gating is taken in only while the input clock is low, so no output ever shows a shortened high pulse.

Top module: `fanout_cfg_slave`

## Requirements
- R1: An address byte of 0xD2 (write) or 0xD3 (read), sent MSB first, is acknowledged by pulling SDA low in the ninth clock. Any other address byte gets no acknowledge, and the bytes that follow it until the next stop change nothing.
- R2: In a write, the first two bytes after the address are acknowledged and their values affect no register.
- R3: The write data bytes that follow load register 0, 1, 2 and so on, in that order, and each one is acknowledged. Bytes after the seventh data byte are also acknowledged but are discarded.
- R4: A stop after any complete byte keeps the registers already written and leaves all other registers as they were.
- R5: A read returns the length byte 7 first, then registers 0 to 6, all MSB first. The block keeps sending bytes while the host acknowledges them, and it releases SDA after a host not-acknowledge.
- R6: Output n for n = 0..3 is enabled by register 0 bit n. Output n for n = 4..7 is enabled by register 2 bit n. Outputs 8 and 9 are enabled by register 1 bits 6 and 7. The other register bits have no effect on the outputs and read back as written.
- R7: An enabled output equals the input clock. A disabled output is held at 0. Every output is 0 while the input clock is low.
- R8: After reset every register reads 0xFF, all ten outputs are enabled, and SDA is released.
- R9: The output drive enable follows the global enable input. When that input is 0, all ten outputs are in high impedance, whatever the registers hold.
- R10: A change of an enable bit reaches its output only while the input clock is low. While the input clock stays high, the outputs do not change.
- R11: SDA and SCL pass through a synchroniser before start and stop are decoded, and the SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| ref_clk_i | input | 1 | Buffered input clock to fan out |
| oe_i | input | 1 | Global output enable, 0 puts all outputs in high impedance |
| clk_o | output | 10 | Gated clock outputs |
| clk_oe_o | output | 1 | Pad drive enable for all clock outputs |

## Verification
Two functions can act in the same system cycle: a write completes and loads a register while the input clock is high, and the output gate must at that moment hold the enable it already has. The bench runs the input clock freely through every write, so register loads fall in both clock phases without being steered. A monitor flags any output change while the input clock stays high, and the outputs are then compared in the following high phase against the enable pattern predicted from the bytes written.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int NUM_OUT = 10;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_HACK
  } eng_st_e;
endpackage

// File: rtl/scl_sda_sync.sv
module scl_sda_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s      = scl_sr[STAGES-1];
  assign sda_s      = sda_sr[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/blk_cfg_engine.sv
module blk_cfg_engine
  import fcs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sda_i,
  input  logic                  scl_rise_i,
  input  logic                  scl_fall_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int IDX_W   = $clog2(NUM_REGS + 4);
  localparam int IDX_MAX = NUM_REGS + 3;

  eng_st_e    st_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q;
  logic [IDX_W-1:0] idx_q;
  logic       rd_q, addr_ph_q, nack_q, oe_q;
  logic [7:0] regs_q [NUM_REGS];
  logic [7:0] rd_byte;
  logic [IDX_W-1:0] idx_nx;

  assign idx_nx = (idx_q == IDX_W'(IDX_MAX)) ? idx_q : idx_q + 1'b1;

  always_comb begin
    rd_byte = 8'hFF;
    if (idx_q == '0) rd_byte = 8'(NUM_REGS);
    for (int k = 0; k < NUM_REGS; k++)
      if (idx_q == IDX_W'(k + 1)) rd_byte = regs_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
      rd_q      <= 1'b0;
      addr_ph_q <= 1'b0;
      nack_q    <= 1'b0;
      oe_q      <= 1'b0;
      for (int k = 0; k < NUM_REGS; k++) regs_q[k] <= 8'hFF;
    end else if (start_i) begin
      st_q      <= S_RX;
      addr_ph_q <= 1'b1;
      cnt_q     <= '0;
      idx_q     <= '0;
      oe_q      <= 1'b0;
    end else if (stop_i) begin
      st_q <= S_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_RX: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            if (addr_ph_q) begin
              addr_ph_q <= 1'b0;
              if (sh_q[7:1] == DEV_ADDR) begin
                rd_q <= sh_q[0];
                oe_q <= 1'b1;
                st_q <= S_ACK;
              end else begin
                st_q <= S_IDLE;
              end
            end else begin
              oe_q  <= 1'b1;
              st_q  <= S_ACK;
              idx_q <= idx_nx;
              for (int k = 0; k < NUM_REGS; k++)
                if (idx_q == IDX_W'(k + 2)) regs_q[k] <= sh_q;
            end
          end
        end
        S_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (rd_q) begin
              sh_q  <= rd_byte;
              oe_q  <= ~rd_byte[7];
              idx_q <= idx_nx;
              st_q  <= S_TX;
            end else begin
              oe_q <= 1'b0;
              st_q <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              oe_q <= 1'b0;
              st_q <= S_HACK;
            end else begin
              sh_q  <= {sh_q[6:0], 1'b0};
              oe_q  <= ~sh_q[6];
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        S_HACK: begin
          if (scl_rise_i) nack_q <= sda_i;
          else if (scl_fall_i) begin
            if (nack_q) begin
              st_q <= S_IDLE;
            end else begin
              cnt_q <= '0;
              sh_q  <= rd_byte;
              oe_q  <= ~rd_byte[7];
              idx_q <= idx_nx;
              st_q  <= S_TX;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_o[g*8 +: 8] = regs_q[g];
  end
endmodule

// File: rtl/out_gate.sv
module out_gate #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ref_clk_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] clk_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic gate_q;
    // take a new enable only in the low phase of the fanned-out clock
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         gate_q <= 1'b1;
      else if (!ref_clk_i) gate_q <= en_i[g];
    end
    assign clk_o[g] = ref_clk_i & gate_q;
  end
endmodule

// File: rtl/fanout_cfg_slave.sv
module fanout_cfg_slave
  import fcs_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               ref_clk_i,
  input  logic               oe_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic               clk_oe_o
);
  logic sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic [NUM_REGS*8-1:0] regs_flat;
  logic [NUM_OUT-1:0]    en;

  scl_sda_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  blk_cfg_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) i_eng (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_p), .stop_i(stop_p),
    .sda_oe_o, .regs_o(regs_flat)
  );

  // out 9:8 <- reg1[7:6], out 7:4 <- reg2[7:4], out 3:0 <- reg0[3:0]
  assign en = {regs_flat[15:14], regs_flat[23:20], regs_flat[3:0]};

  out_gate #(.N(NUM_OUT)) i_gate (
    .clk_i, .rst_ni, .ref_clk_i, .en_i(en), .clk_o
  );

  assign clk_oe_o = oe_i;
endmodule

// File: rtl/fanout_cfg_chk.sv
module fanout_cfg_chk #(
  parameter int N  = 10,
  parameter int RW = 56
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          ref_clk_i,
  input logic          sda_oe_o,
  input logic [N-1:0]  clk_o,
  input logic [RW-1:0] regs_flat
);
  AST_LOW_WHEN_REF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_clk_i |-> clk_o == '0); // R7

  AST_NO_RUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_clk_i && $past(ref_clk_i) |-> clk_o == $past(clk_o)); // R10

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o != $past(sda_oe_o) |-> !scl_i); // R11

  AST_LOAD_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_flat != $past(regs_flat) |-> sda_oe_o); // R3
endmodule

bind fanout_cfg_slave fanout_cfg_chk #(.N(fcs_pkg::NUM_OUT), .RW(NUM_REGS*8)) i_chk (
  .clk_i, .rst_ni, .scl_i, .ref_clk_i, .sda_oe_o, .clk_o, .regs_flat
);

// File: tb/test_fanout_cfg_slave.sv
module test_fanout_cfg_slave;
  localparam int T = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic ref_clk = 1'b0, oe = 1'b1;
  logic sda_oe, clk_oe;
  logic [9:0] clk_out;
  logic sda_line;
  int errors = 0, checks = 0;
  int runt_cnt = 0, sda_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];

  assign sda_line = host_sda & ~sda_oe;

  always #5 clk = ~clk;

  fanout_cfg_slave i_fanout_cfg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .ref_clk_i(ref_clk), .oe_i(oe),
    .clk_o(clk_out), .clk_oe_o(clk_oe)
  );

  initial forever begin
    repeat (4) @(posedge clk);
    #2 ref_clk = ~ref_clk;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitors: R10 output change during stable high ref, R11 sda drive change with scl high
  logic [9:0] prev_out;
  logic prev_ref, prev_oe;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ref_clk && prev_ref && clk_out != prev_out) runt_cnt++;
      if (sda_oe != prev_oe && host_scl) sda_bad++;
    end
    prev_out = clk_out;
    prev_ref = ref_clk;
    prev_oe  = sda_oe;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(a == e, t, {8'h0, a}, {8'h0, e});
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    host_sda = 1'b1; host_scl = 1'b1; wt(T);
    host_sda = 1'b0; wt(T);
    host_scl = 1'b0; wt(T);
  endtask

  task automatic i2c_stop();
    host_sda = 1'b0; wt(T);
    host_scl = 1'b1; wt(T);
    host_sda = 1'b1; wt(T);
  endtask

  task automatic put_bit(input logic b);
    host_sda = b; wt(T);
    host_scl = 1'b1; wt(T);
    host_scl = 1'b0; wt(T);
  endtask

  task automatic get_bit(output logic b);
    host_sda = 1'b1; wt(T);
    host_scl = 1'b1; wt(T/2);
    b = sda_line; wt(T/2);
    host_scl = 1'b0; wt(T);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic rd_byte(input bit last, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(last);
  endtask

  task automatic push_exp(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // read the length byte plus regs; expected items pushed by caller
  task automatic read_txn(input string tag);
    logic a;
    logic [7:0] v;
    i2c_start();
    wr_byte(8'hD3, a);
    chk(a, {tag, " R1 read addr ack"}, {15'h0, a}, 16'h1);
    for (int k = 0; k < 8; k++) begin
      rd_byte(k == 7, v);
      act_q.push_back(v);
    end
    i2c_stop();
    chk(sda_oe == 1'b0, "R5 released after nack", {15'h0, sda_oe}, 16'h0);
    wt(4);
  endtask

  task automatic expect_regs(input logic [7:0] r [7], input string t);
    push_exp(8'd7, {t, " R5 length"});
    for (int k = 0; k < 7; k++) push_exp(r[k], t);
  endtask

  task automatic write_txn(input logic [7:0] d [$], input string tag);
    logic a;
    i2c_start();
    wr_byte(8'hD2, a);
    chk(a, {tag, " R1 write addr ack"}, {15'h0, a}, 16'h1);
    wr_byte(8'h5C, a);
    chk(a, {tag, " R2 cmd ack"}, {15'h0, a}, 16'h1);
    wr_byte(8'h03, a);
    chk(a, {tag, " R2 count ack"}, {15'h0, a}, 16'h1);
    foreach (d[i]) begin
      wr_byte(d[i], a);
      chk(a, {tag, " R3 data ack"}, {15'h0, a}, 16'h1);
    end
    i2c_stop();
  endtask

  task automatic check_outs(input logic [9:0] en, input string t);
    wt(20);
    while (!ref_clk) @(negedge clk);
    chk(clk_out == en, {t, " high phase"}, {6'h0, clk_out}, {6'h0, en});
    while (ref_clk) @(negedge clk);
    chk(clk_out == 10'h0, "R7 low phase", {6'h0, clk_out}, 16'h0);
  endtask

  initial begin
    logic [7:0] r [7];
    logic [7:0] d [$];
    logic a;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0, "R8 sda released in reset", {15'h0, sda_oe}, 16'h0);
    rst_n = 1'b1;
    check_outs(10'h3FF, "R8 all enabled");

    r = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    expect_regs(r, "R8 reset regs");
    read_txn("reset");

    // R6 mapping: en = 01_1010_0101
    d = '{8'h05, 8'h40, 8'hA0};
    write_txn(d, "w1");
    check_outs(10'h1A5, "R6 R7 map");
    r = '{8'h05, 8'h40, 8'hA0, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    expect_regs(r, "R3 R4 readback");
    read_txn("rb1");

    // R1 foreign address, then bytes that must be ignored
    i2c_start();
    wr_byte(8'hA0, a);
    chk(!a, "R1 foreign addr no ack", {15'h0, a}, 16'h0);
    for (int k = 0; k < 4; k++) wr_byte(8'h00, a);
    i2c_stop();
    expect_regs(r, "R1 ignored");
    read_txn("rb2");

    // R3 overflow bytes acked and dropped
    d = '{8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17, 8'h18, 8'h19, 8'h1A};
    write_txn(d, "w2");
    r = '{8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17};
    expect_regs(r, "R3 overflow");
    read_txn("rb3");

    // R4 stop after first data byte
    d = '{8'h0F};
    write_txn(d, "w3");
    r = '{8'h0F, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17};
    expect_regs(r, "R4 partial");
    read_txn("rb4");
    check_outs(10'h01F, "R6 partial map");

    // R9 global enable
    oe = 1'b0; wt(3);
    chk(clk_oe == 1'b0, "R9 tri-state", {15'h0, clk_oe}, 16'h0);
    oe = 1'b1; wt(3);
    chk(clk_oe == 1'b1, "R9 drive", {15'h0, clk_oe}, 16'h1);

    wt(20);
    chk(exp_q.size() == 0 && act_q.size() == 0, "R5 scoreboard drained",
        16'(exp_q.size()), 16'(act_q.size()));
    chk(runt_cnt == 0, "R10 no change in high phase", 16'(runt_cnt), 16'h0);
    chk(sda_bad == 0, "R11 sda moves with scl low", 16'(sda_bad), 16'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule